// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Control Path

A small synchronous static memory with four 9-bit byte lanes and a pipelined read path. Every control, address and data input is taken into a register on the rising clock edge. The registered request is then carried out one edge later. A selected read loads the addressed word into an output register, so its data appears after the second rising edge from the one that took the request.

Writes are decoded from three sources. A global write enable stores all four lanes and overrides everything else. A byte-write enable stores only the lanes whose individual select is active. Three synchronous chip enables must all agree before any access is carried out.

A data-drive flag stands in for the three-state data bus. The flag is low when no read result is present, while a write is in progress, or when the output enable is inactive. The output enable reaches the flag through logic only, with no register in its path. The read slot that directly follows a deselected cycle is never driven. This keeps banks that share a bus from clashing when the part is used for depth expansion.

Top module: `pipe_sram`

## Requirements
- R1: A read request taken at rising edge k places its word on `rdData`, with `rdDrive` high, after edge k+1. Back-to-back reads come out in the order they were issued.
- R2: With `globalWrN`=1 and `byteWrEnN`=0, exactly the lanes whose `laneSelN` bit is 0 are written. Lane i is data bits [9i+8:9i], and the other lanes keep their contents.
- R3: With `globalWrN`=0, all four lanes are written, whatever the values of `byteWrEnN` and `laneSelN`.
- R4: With `globalWrN`=1 and `byteWrEnN`=1, the cycle is a read and leaves the memory unchanged, even if `laneSelN` bits are 0.
- R5: An access is selected only when `selAN`=0, `selB`=1 and `selCN`=0. In any other case nothing is written or read, and the data slot of that cycle has `rdDrive`=0. A slot that follows a driven read can already be undriven.
- R6: A write cycle is one with `globalWrN`=0 or `byteWrEnN`=0. Its data slot (after the next edge) has `rdDrive`=0.
- R7: A read whose previous cycle was deselected, including the first cycle after reset, is not driven in its data slot, even with `outEnN`=0. A read that follows a selected cycle, including a write, is driven.
- R8: `outEnN`=1 forces `rdDrive` to 0 and `rdData` to 0 without any clock edge. Returning it to 0 restores a valid slot at once.
- R9: After reset, `rdDrive` is 0. Whenever `rdDrive` is 0, `rdData` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (6) | Word address |
| selAN | input | 1 | Chip enable, active low |
| selB | input | 1 | Chip enable, active high |
| selCN | input | 1 | Chip enable, active low |
| globalWrN | input | 1 | Global write of all lanes, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneSelN | input | 4 | Per-lane write selects, active low |
| wrData | input | 36 | Write data, four 9-bit lanes |
| outEnN | input | 1 | Output enable without a clock, active low |
| rdData | output | 36 | Read data, zero when not driven |
| rdDrive | output | 1 | High when the data bus would be driven |

## Verification
The main overlap is a write and a read of the same address in adjacent cycles. The write's array update happens on the same edge that takes the read request. The bench issues a global write and then an immediate read of that word. It expects the new word, driven, one edge later, because a write cycle counts as selected and must not mask the following read. A second overlap places an output-enable change inside a driven slot, with no clock edge in between. The flag must follow the enable within a fraction of a cycle, while the pipeline state stays intact.

// File: rtl/pipe_sram_pkg.sv
`timescale 1ns/1ps
package pipe_sram_pkg;
  localparam int LANES = 4;

  // strobes from control to datapath, valid during the execute cycle
  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [LANES-1:0] laneWr;
  } strobe_t;
endpackage

// File: rtl/pipe_sram_ctrl.sv
`timescale 1ns/1ps
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             selAN,
  input  logic             selB,
  input  logic             selCN,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] laneSelN,
  input  logic             outEnN,
  output strobe_t          strobe,
  output logic             rdDrive
);
  logic             selNow;
  logic             wrNow;
  logic [LANES-1:0] laneNow;

  logic             selQ, wrQ, prevSelQ, rdVldQ, maskQ;
  logic [LANES-1:0] laneQ;

  assign selNow = !selAN && selB && !selCN;
  assign wrNow  = !globalWrN || !byteWrEnN;

  // global write wins over the per-lane selects
  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign laneNow[i] = !globalWrN || (!byteWrEnN && !laneSelN[i]);
  end

  // input stage plus slot-state registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ     <= 1'b0;
      wrQ      <= 1'b0;
      laneQ    <= '0;
      prevSelQ <= 1'b0;
      rdVldQ   <= 1'b0;
      maskQ    <= 1'b0;
    end else begin
      selQ     <= selNow;
      wrQ      <= wrNow;
      laneQ    <= selNow ? laneNow : '0;
      prevSelQ <= selQ;
      rdVldQ   <= selQ && !wrQ;
      maskQ    <= selQ && !wrQ && !prevSelQ;
    end
  end

  always_comb begin
    strobe.rdEn   = selQ && !wrQ;
    strobe.wrEn   = selQ && wrQ;
    strobe.laneWr = strobe.wrEn ? laneQ : '0;
  end

  // output enable joins without a register
  assign rdDrive = rdVldQ && !maskQ && !outEnN;

  a_r3_global_all: assert property (@(posedge clk) disable iff (!rstN)
    (selNow && !globalWrN) |=> (strobe.laneWr == '1));

  a_r2_byte_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (selNow && globalWrN && !byteWrEnN) |=> (strobe.laneWr == ~$past(laneSelN)));

  a_r4_plain_read: assert property (@(posedge clk) disable iff (!rstN)
    (selNow && globalWrN && byteWrEnN) |=> (!strobe.wrEn && strobe.rdEn));

  a_r5_desel_idle: assert property (@(posedge clk) disable iff (!rstN)
    !selNow |=> (strobe.laneWr == '0 && !strobe.rdEn));

  a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> !rdDrive);

  a_r7_first_masked: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && !prevSelQ) |=> !rdDrive);
endmodule

// File: rtl/pipe_sram_data.sv
`timescale 1ns/1ps
module pipe_sram_data
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  strobe_t                 strobe,
  input  logic                    rdDrive,
  output logic [LANES*LANE_W-1:0] rdData
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] dataQ;
  logic [WORD_W-1:0] doutQ;

  // address and write data input registers
  always_ff @(posedge clk) begin
    addrQ <= addr;
    dataQ <= wrData;
  end

  // lane-masked array write
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (strobe.laneWr[i])
        mem[addrQ][i*LANE_W +: LANE_W] <= dataQ[i*LANE_W +: LANE_W];
    end
  end

  // output register of the read pipeline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            doutQ <= '0;
    else if (strobe.rdEn) doutQ <= mem[addrQ];
  end

  assign rdData = rdDrive ? doutQ : '0;

  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> (rdData == '0));
endmodule

// File: rtl/pipe_sram.sv
`timescale 1ns/1ps
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    selAN,
  input  logic                    selB,
  input  logic                    selCN,
  input  logic                    globalWrN,
  input  logic                    byteWrEnN,
  input  logic [LANES-1:0]        laneSelN,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);
  strobe_t strobe;

  pipe_sram_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .selAN     (selAN),
    .selB      (selB),
    .selCN     (selCN),
    .globalWrN (globalWrN),
    .byteWrEnN (byteWrEnN),
    .laneSelN  (laneSelN),
    .outEnN    (outEnN),
    .strobe    (strobe),
    .rdDrive   (rdDrive)
  );

  pipe_sram_data #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrData  (wrData),
    .strobe  (strobe),
    .rdDrive (rdDrive),
    .rdData  (rdData)
  );
endmodule

// File: tb/sim_pipe_sram.sv
`timescale 1ns/1ps
module sim_pipe_sram;
  localparam logic [2:0] ON  = 3'b010;  // {selAN, selB, selCN}
  localparam logic [2:0] OFF = 3'b110;

  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  addr;
  logic        selAN, selB, selCN, globalWrN, byteWrEnN, outEnN;
  logic [3:0]  laneSelN;
  logic [35:0] wrData, rdData;
  logic        rdDrive;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [35:0] val3, val5, val7;

  always #2.5 clk = ~clk;

  pipe_sram u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .selAN(selAN), .selB(selB),
    .selCN(selCN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneSelN(laneSelN), .wrData(wrData), .outEnN(outEnN),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chkRead(input string req, input logic [35:0] exp);
    chk(req, {35'd0, rdDrive}, 36'd1);
    chk(req, rdData, exp);
  endtask

  task automatic chkQuiet(input string req);
    chk(req, {35'd0, rdDrive}, 36'd0);
    chk(req, rdData, 36'd0);
  endtask

  // apply one request at a falling edge, return at the next falling edge
  task automatic drv(input logic [2:0] ce, input logic gwN, input logic bweN,
                     input logic [3:0] bsN, input logic [5:0] a, input logic [35:0] d);
    {selAN, selB, selCN} = ce;
    globalWrN = gwN;
    byteWrEnN = bweN;
    laneSelN  = bsN;
    addr      = a;
    wrData    = d;
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a);   drv(ON, 1'b1, 1'b1, 4'hf, a, 36'd0); endtask
  task automatic idle();                    drv(OFF, 1'b1, 1'b1, 4'hf, 6'd0, 36'd0); endtask

  // two reads so the second is unmasked; returns in the second read's slot
  task automatic readBack(input logic [5:0] a);
    rd(a); rd(a); idle();
  endtask

  function automatic logic [35:0] laneMask(input logic [3:0] bsN);
    logic [35:0] m = '0;
    for (int i = 0; i < 4; i++) if (!bsN[i]) m[i*9 +: 9] = 9'h1ff;
    return m;
  endfunction

  task automatic t_reset();
    chkQuiet("R9 reset");
  endtask

  task automatic t_global();
    val3 = 36'h9_A5C3_1E7B;
    // global write with byte enable active and mixed selects: all lanes
    drv(ON, 1'b0, 1'b0, 4'b0101, 6'd3, val3);
    idle();
    chkQuiet("R6 write slot");
    readBack(6'd3);
    chkRead("R3 global write", val3);
  endtask

  task automatic t_byte();
    logic [35:0] newD;
    logic [3:0]  pats [2];
    pats[0] = 4'b1010;
    pats[1] = 4'b0110;
    val5 = 36'h1_2345_6789;
    drv(ON, 1'b0, 1'b1, 4'hf, 6'd5, val5);
    for (int p = 0; p < 2; p++) begin
      newD = 36'hF_EDCB_A987 ^ {32'd0, 4'(p)};
      drv(ON, 1'b1, 1'b0, pats[p], 6'd5, newD);
      val5 = (val5 & ~laneMask(pats[p])) | (newD & laneMask(pats[p]));
      readBack(6'd5);
      chkRead("R2 byte lanes", val5);
    end
  endtask

  task automatic t_noBwe();
    drv(ON, 1'b1, 1'b1, 4'h0, 6'd5, 36'h0_0000_0000);
    idle();
    readBack(6'd5);
    chkRead("R4 no enable keeps word", val5);
  endtask

  task automatic t_desel();
    logic [2:0] badCe [3];
    badCe[0] = 3'b110; badCe[1] = 3'b000; badCe[2] = 3'b011;
    val7 = 36'h5_5AA5_0FF0;
    drv(ON, 1'b0, 1'b1, 4'hf, 6'd7, val7);
    for (int k = 0; k < 3; k++) begin
      drv(badCe[k], 1'b0, 1'b1, 4'hf, 6'd7, 36'hF_FFFF_FFFF);
      chk("R5 deselect write slot", {35'd0, rdDrive}, 36'd0);
    end
    rd(6'd7); rd(6'd7);
    drv(badCe[1], 1'b1, 1'b1, 4'hf, 6'd7, 36'd0);
    chkRead("R5 read before deselect", val7);
    idle();
    chkQuiet("R5 single cycle deselect");
    readBack(6'd7);
    chkRead("R5 deselected writes ignored", val7);
  endtask

  task automatic t_mask();
    idle();
    rd(6'd3);
    rd(6'd5);
    chkQuiet("R7 first read after deselect");
    idle();
    chkRead("R7 next read driven", val5);
    // a read right after a write is not masked and sees the new word
    drv(ON, 1'b0, 1'b1, 4'hf, 6'd9, 36'hC_0FFE_E123);
    rd(6'd9);
    idle();
    chkRead("R7 read after write", 36'hC_0FFE_E123);
  endtask

  task automatic t_order();
    rd(6'd7);          // selected predecessor
    rd(6'd3);
    rd(6'd5);
    chkRead("R1 first in order", val3);
    idle();
    chkRead("R1 second in order", val5);
  endtask

  task automatic t_outEn();
    rd(6'd3); rd(6'd3); idle();
    chkRead("R8 before disable", val3);
    outEnN = 1'b1;
    #0.5;
    chkQuiet("R8 disable without clock");
    outEnN = 1'b0;
    #0.5;
    chkRead("R8 enable without clock", val3);
  endtask

  initial begin
    rstN = 1'b0;
    outEnN = 1'b0;
    {selAN, selB, selCN} = OFF;
    globalWrN = 1'b1; byteWrEnN = 1'b1; laneSelN = 4'hf;
    addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_global();
    t_byte();
    t_noBwe();
    t_desel();
    t_mask();
    t_order();
    t_outEn();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule